// File: doc/BRIEF.md
# Dual-Port Scratchpad Bank with Read-Set Semaphore

This block holds a small bank of 32-bit scratchpad words that two independent hosts reach through two identical ports, labelled A and B. It also holds one bit of ownership state, the semaphore. The hosts use the semaphore to agree on who may use the bank. Reading the semaphore returns its value and leaves it set, so a reader that sees 0 has just taken ownership. Writing a 1 to it releases ownership. The semaphore is advisory only: it never blocks a scratchpad write.

A mode pin selects one of two organisations. In shared mode both ports act on one local bank. In back-to-back mode the two systems each keep their own bank. A port's writes then leave the block on a per-port remote-write output, one cycle later, and reads are still served from the local bank. Carrying those forwarded writes across a link is outside this block.

Top module: `spad_sema_bank`

## Requirements
- R1: In shared mode (`mode_b2b`=0), addresses 0 to 15 select one of sixteen 32-bit words. A write from either port is returned by any later read of that word from either port.
- R2: Address 16 is the semaphore. A read there returns the semaphore's prior value in bit 0, with all upper bits 0, and leaves the semaphore at 1. A reader that sees 0 has acquired ownership.
- R3: A semaphore read while the semaphore is already 1 returns 1, and the semaphore stays 1.
- R4: In shared mode, a write to address 16 with `wr_data[0]`=1 clears the semaphore. If any semaphore read happens in the same cycle, the read's set takes precedence and the semaphore ends at 1.
- R5: A write to address 16 with `wr_data[0]`=0 leaves the semaphore unchanged.
- R6: Scratchpad writes from either port take effect whether or not the semaphore is held.
- R7: In back-to-back mode (`mode_b2b`=1), a write to address 0 to 16 changes neither the local bank nor the semaphore. In the next cycle that port's `rmt_vld` is 1 for one cycle, with `rmt_addr` and `rmt_data` equal to the write's address and data. Reads still return local state.
- R8: If both ports read the semaphore in the same cycle, port A gets the prior value and port B gets 1.
- R9: Read data appears on `rd_data` one cycle after `rd_en`, and `rd_data` holds its value while `rd_en` is 0. A read of a word that is written in the same cycle returns the old contents.
- R10: If both ports write the same word in the same cycle in shared mode, port A's data is kept.
- R11: Addresses above 16 read as 0. Writes to them change nothing and are never forwarded.
- R12: After reset all words, the semaphore, both `rd_data` outputs and all remote-write outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_b2b | input | 1 | 0 = shared bank, 1 = back-to-back forwarding |
| a_addr | input | 5 | Port A word address (16 = semaphore) |
| a_wr_en | input | 1 | Port A write strobe |
| a_wr_data | input | 32 | Port A write data |
| a_rd_en | input | 1 | Port A read strobe |
| a_rd_data | output | 32 | Port A registered read data |
| a_rmt_vld | output | 1 | Port A forwarded write valid |
| a_rmt_addr | output | 5 | Port A forwarded write address |
| a_rmt_data | output | 32 | Port A forwarded write data |
| b_addr | input | 5 | Port B word address (16 = semaphore) |
| b_wr_en | input | 1 | Port B write strobe |
| b_wr_data | input | 32 | Port B write data |
| b_rd_en | input | 1 | Port B read strobe |
| b_rd_data | output | 32 | Port B registered read data |
| b_rmt_vld | output | 1 | Port B forwarded write valid |
| b_rmt_addr | output | 5 | Port B forwarded write address |
| b_rmt_data | output | 32 | Port B forwarded write data |

## Verification
The bench targets the semaphore races: both ports reading in one cycle, which would hand ownership to both hosts if the port B view ignored port A's read, and a read meeting a release in one cycle, which a design that let the clear win would leave unowned. It writes to a word while another host holds the semaphore, so a design that gated writes on ownership would return stale data. It sends writes in back-to-back mode and checks that local state stays unchanged, so a design that also wrote locally would be caught by a later local read. It also covers a read and a write of the same word in one cycle, where a bypassing design would return the new data, and two writes to the same word in one cycle, where a design with port B priority would keep the wrong value.

// File: rtl/spad_pkg.sv
package spad_pkg;

   // Per-port decoded intent, produced by the address decoder.
   typedef struct packed {
      logic loc_wr;    // update a local scratchpad word
      logic fwd;       // send the write to the remote bank
      logic sema_rd;   // read of the semaphore location
      logic sema_clr;  // release request for the semaphore
   } port_req_t;

   localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/spad_port_dec.sv
module spad_port_dec
   import spad_pkg::*;
#(
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned ADDR_W   = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              wr_lsb,
   input  logic              rd_en,
   input  logic              b2b,
   output port_req_t         req,
   output logic              in_bank
);
   localparam logic [ADDR_W-1:0] SEMA_IDX = ADDR_W'(NUM_REGS);

   logic is_sema;

   always_comb begin
      in_bank      = (addr < SEMA_IDX);
      is_sema      = (addr == SEMA_IDX);
      req.loc_wr   = wr_en & ~b2b & in_bank;
      req.fwd      = wr_en & b2b & (in_bank | is_sema);
      req.sema_rd  = rd_en & is_sema;
      req.sema_clr = wr_en & ~b2b & is_sema & wr_lsb;
   end
endmodule

// File: rtl/spad_regfile.sv
module spad_regfile #(
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_a,
   input  logic [IDX_W-1:0]                 idx_a,
   input  logic [DATA_W-1:0]                d_a,
   input  logic                             we_b,
   input  logic [IDX_W-1:0]                 idx_b,
   input  logic [DATA_W-1:0]                d_b,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  words
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we_a && idx_a == IDX_W'(i))
            q <= d_a;                         // port A wins a collision
         else if (we_b && idx_b == IDX_W'(i))
            q <= d_b;
      end
      assign words[i] = q;
   end
endmodule

// File: rtl/spad_sema.sv
module spad_sema (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_a,
   input  logic rd_b,
   input  logic clr_a,
   input  logic clr_b,
   output logic held,
   output logic view_a,
   output logic view_b
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held <= 1'b0;
      else if (rd_a || rd_b)
         held <= 1'b1;                        // a read sets, even against a clear
      else if (clr_a || clr_b)
         held <= 1'b0;
   end

   // Port A is served first; port B sees the result of A's read.
   assign view_a = held;
   assign view_b = held | rd_a;
endmodule

// File: rtl/spad_sema_bank.sv
module spad_sema_bank
   import spad_pkg::*;
#(
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_b2b,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_wr_en,
   input  logic [DATA_W-1:0] a_wr_data,
   input  logic              a_rd_en,
   output logic [DATA_W-1:0] a_rd_data,
   output logic              a_rmt_vld,
   output logic [ADDR_W-1:0] a_rmt_addr,
   output logic [DATA_W-1:0] a_rmt_data,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_wr_en,
   input  logic [DATA_W-1:0] b_wr_data,
   input  logic              b_rd_en,
   output logic [DATA_W-1:0] b_rd_data,
   output logic              b_rmt_vld,
   output logic [ADDR_W-1:0] b_rmt_addr,
   output logic [DATA_W-1:0] b_rmt_data
);
   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2) begin : g_bad_regs
      $error("spad_sema_bank: NUM_REGS must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("spad_sema_bank: DATA_W must be at least 1");
   end
   if (ADDR_W < $clog2(NUM_REGS + 1)) begin : g_bad_addr
      $error("spad_sema_bank: ADDR_W too narrow for bank plus semaphore");
   end

   logic [ADDR_W-1:0] addr_v  [NUM_PORTS];
   logic [DATA_W-1:0] wdata_v [NUM_PORTS];
   logic              we_v    [NUM_PORTS];
   logic              re_v    [NUM_PORTS];
   port_req_t         req     [NUM_PORTS];
   logic              inb     [NUM_PORTS];
   logic              view    [NUM_PORTS];

   assign addr_v[0]  = a_addr;     assign addr_v[1]  = b_addr;
   assign wdata_v[0] = a_wr_data;  assign wdata_v[1] = b_wr_data;
   assign we_v[0]    = a_wr_en;    assign we_v[1]    = b_wr_en;
   assign re_v[0]    = a_rd_en;    assign re_v[1]    = b_rd_en;

   logic [NUM_REGS-1:0][DATA_W-1:0] words;
   logic                            sema_held;

   spad_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we_a  (req[0].loc_wr),
      .idx_a (addr_v[0][IDX_W-1:0]),
      .d_a   (wdata_v[0]),
      .we_b  (req[1].loc_wr),
      .idx_b (addr_v[1][IDX_W-1:0]),
      .d_b   (wdata_v[1]),
      .words (words)
   );

   spad_sema u_sema (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_a   (req[0].sema_rd),
      .rd_b   (req[1].sema_rd),
      .clr_a  (req[0].sema_clr),
      .clr_b  (req[1].sema_clr),
      .held   (sema_held),
      .view_a (view[0]),
      .view_b (view[1])
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [DATA_W-1:0] rd_q;
      logic              rmt_v;
      logic [ADDR_W-1:0] rmt_a;
      logic [DATA_W-1:0] rmt_d;

      spad_port_dec #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
         .addr    (addr_v[p]),
         .wr_en   (we_v[p]),
         .wr_lsb  (wdata_v[p][0]),
         .rd_en   (re_v[p]),
         .b2b     (mode_b2b),
         .req     (req[p]),
         .in_bank (inb[p])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_q <= '0;
         else if (re_v[p]) begin
            if (inb[p])
               rd_q <= words[addr_v[p][IDX_W-1:0]];
            else if (req[p].sema_rd)
               rd_q <= DATA_W'(view[p]);
            else
               rd_q <= '0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rmt_v <= 1'b0;
            rmt_a <= '0;
            rmt_d <= '0;
         end else begin
            rmt_v <= req[p].fwd;
            if (req[p].fwd) begin
               rmt_a <= addr_v[p];
               rmt_d <= wdata_v[p];
            end
         end
      end
   end

   assign a_rd_data  = g_port[0].rd_q;
   assign a_rmt_vld  = g_port[0].rmt_v;
   assign a_rmt_addr = g_port[0].rmt_a;
   assign a_rmt_data = g_port[0].rmt_d;
   assign b_rd_data  = g_port[1].rd_q;
   assign b_rmt_vld  = g_port[1].rmt_v;
   assign b_rmt_addr = g_port[1].rmt_a;
   assign b_rmt_data = g_port[1].rmt_d;
endmodule

// File: rtl/spad_sema_bank_chk.sv
module spad_sema_bank_chk #(
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_b2b,
   input logic [ADDR_W-1:0] a_addr,
   input logic              a_wr_en,
   input logic [DATA_W-1:0] a_wr_data,
   input logic              a_rd_en,
   input logic [DATA_W-1:0] a_rd_data,
   input logic              a_rmt_vld,
   input logic [ADDR_W-1:0] b_addr,
   input logic              b_wr_en,
   input logic [DATA_W-1:0] b_wr_data,
   input logic              b_rd_en,
   input logic [DATA_W-1:0] b_rd_data,
   input logic              sema_held
);
   localparam logic [ADDR_W-1:0] SEMA = ADDR_W'(NUM_REGS);

   logic a_srd, b_srd, a_clr, b_clr;
   assign a_srd = a_rd_en && a_addr == SEMA;
   assign b_srd = b_rd_en && b_addr == SEMA;
   assign a_clr = !mode_b2b && a_wr_en && a_addr == SEMA && a_wr_data[0];
   assign b_clr = !mode_b2b && b_wr_en && b_addr == SEMA && b_wr_data[0];

   // R2: any semaphore read leaves it held
   p_sema_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_srd || b_srd) |=> sema_held);

   // R3: reading while held returns 1
   p_held_reads_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_srd && sema_held) |=> a_rd_data == DATA_W'(1));

   // R4: a release with no competing read clears it
   p_sema_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((a_clr || b_clr) && !a_srd && !b_srd) |=> !sema_held);

   // R5: without a read or a release the semaphore keeps its value
   p_sema_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_clr && !b_clr && !a_srd && !b_srd) |=> $stable(sema_held));

   // R7: forwarding of port A writes in back-to-back mode
   p_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_b2b && a_wr_en && a_addr <= SEMA) |=> a_rmt_vld);
   p_no_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_b2b && a_wr_en && a_addr <= SEMA) |=> !a_rmt_vld);

   // R8: simultaneous semaphore reads, port B loses
   p_b_loses_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_srd && b_srd) |=> b_rd_data == DATA_W'(1));

   // R9: read data holds while idle
   p_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !a_rd_en |=> $stable(a_rd_data));
   p_hold_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !b_rd_en |=> $stable(b_rd_data));

   // R11: addresses past the semaphore read as zero
   p_oor_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd_en && a_addr > SEMA) |=> a_rd_data == '0);
endmodule

bind spad_sema_bank spad_sema_bank_chk #(
   .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_b2b(mode_b2b),
   .a_addr(a_addr), .a_wr_en(a_wr_en), .a_wr_data(a_wr_data),
   .a_rd_en(a_rd_en), .a_rd_data(a_rd_data), .a_rmt_vld(a_rmt_vld),
   .b_addr(b_addr), .b_wr_en(b_wr_en), .b_wr_data(b_wr_data),
   .b_rd_en(b_rd_en), .b_rd_data(b_rd_data), .sema_held(sema_held)
);

// File: tb/spad_sema_bank_tb.sv
module spad_sema_bank_tb;
   localparam int NR = 16;
   localparam int DW = 32;
   localparam int AW = 5;
   localparam logic [AW-1:0] SEMA = AW'(NR);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          mode_b2b = 1'b0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic          a_wr_en = 1'b0, b_wr_en = 1'b0, a_rd_en = 1'b0, b_rd_en = 1'b0;
   logic [DW-1:0] a_wr_data = '0, b_wr_data = '0;
   logic [DW-1:0] a_rd_data, b_rd_data, a_rmt_data, b_rmt_data;
   logic          a_rmt_vld, b_rmt_vld;
   logic [AW-1:0] a_rmt_addr, b_rmt_addr;

   spad_sema_bank u_dut (
      .clk(clk), .rst_n(rst_n), .mode_b2b(mode_b2b),
      .a_addr(a_addr), .a_wr_en(a_wr_en), .a_wr_data(a_wr_data), .a_rd_en(a_rd_en),
      .a_rd_data(a_rd_data), .a_rmt_vld(a_rmt_vld), .a_rmt_addr(a_rmt_addr), .a_rmt_data(a_rmt_data),
      .b_addr(b_addr), .b_wr_en(b_wr_en), .b_wr_data(b_wr_data), .b_rd_en(b_rd_en),
      .b_rd_data(b_rd_data), .b_rmt_vld(b_rmt_vld), .b_rmt_addr(b_rmt_addr), .b_rmt_data(b_rmt_data)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Scoreboard entry: kind 0/1 = read data A/B, 2/3 = remote write A/B
   typedef struct {
      int          kind;
      logic [63:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   // Reference state, derived from the requirements
   logic [DW-1:0] mdl [NR];
   logic          msema = 1'b0;
   logic [DW-1:0] last_rd [2];
   logic [63:0]   last_rmt [2];
   logic          mode_v = 1'b0;

   function automatic logic [63:0] rmt_pack(logic v, logic [AW-1:0] a, logic [DW-1:0] d);
      return {26'd0, v, a, d};
   endfunction

   task automatic step(string tag,
                       logic [AW-1:0] aa, logic awe, logic [DW-1:0] awd, logic are,
                       logic [AW-1:0] ba, logic bwe, logic [DW-1:0] bwd, logic bre);
      logic [AW-1:0] ad [2];
      logic          we [2];
      logic [DW-1:0] wd [2];
      logic          re [2];
      logic          srd [2];
      logic          clr_any;
      logic [DW-1:0] rv;
      item_t         it;
      @(negedge clk);
      mode_b2b = mode_v;
      a_addr = aa; a_wr_en = awe; a_wr_data = awd; a_rd_en = are;
      b_addr = ba; b_wr_en = bwe; b_wr_data = bwd; b_rd_en = bre;
      ad[0] = aa; we[0] = awe; wd[0] = awd; re[0] = are;
      ad[1] = ba; we[1] = bwe; wd[1] = bwd; re[1] = bre;
      clr_any = 1'b0;
      for (int p = 0; p < 2; p++) begin
         srd[p] = re[p] && ad[p] == SEMA;
         if (!mode_v && we[p] && ad[p] == SEMA && wd[p][0]) clr_any = 1'b1;
      end
      for (int p = 0; p < 2; p++) begin
         if (re[p]) begin
            if (ad[p] < SEMA)       rv = mdl[ad[p][3:0]];
            else if (ad[p] == SEMA) rv = DW'((p == 0) ? msema : (msema | srd[0]));
            else                    rv = '0;
            last_rd[p] = rv;
         end
         it.kind = p; it.exp = {32'd0, last_rd[p]}; it.tag = tag;
         sb.push_back(it);
      end
      if (srd[0] || srd[1]) msema = 1'b1;
      else if (clr_any)     msema = 1'b0;
      for (int p = 1; p >= 0; p--) begin   // A applied last, so A wins
         if (!mode_v && we[p] && ad[p] < SEMA) mdl[ad[p][3:0]] = wd[p];
      end
      for (int p = 0; p < 2; p++) begin
         if (mode_v && we[p] && ad[p] <= SEMA)
            last_rmt[p] = rmt_pack(1'b1, ad[p], wd[p]);
         else
            last_rmt[p][DW+AW] = 1'b0;
         it.kind = 2 + p; it.exp = last_rmt[p]; it.tag = tag;
         sb.push_back(it);
      end
   endtask

   task automatic idle(string tag);
      step(tag, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
   endtask

   // Monitor: compares after each clock edge the items pushed before it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (sb.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb.pop_front();
            case (it.kind)
               0:       act = {32'd0, a_rd_data};
               1:       act = {32'd0, b_rd_data};
               2:       act = rmt_pack(a_rmt_vld, a_rmt_addr, a_rmt_data);
               default: act = rmt_pack(b_rmt_vld, b_rmt_addr, b_rmt_data);
            endcase
            chk($sformatf("%s kind%0d", it.tag, it.kind), act, it.exp);
         end
      end
   end

   bit done = 1'b0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) mdl[i] = '0;
      for (int p = 0; p < 2; p++) begin last_rd[p] = '0; last_rmt[p] = '0; end
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 a_rd_data", {32'd0, a_rd_data}, 64'd0);
      chk("R12 b_rd_data", {32'd0, b_rd_data}, 64'd0);
      chk("R12 rmt", {a_rmt_vld, b_rmt_vld, a_rmt_addr, b_rmt_addr, a_rmt_data | b_rmt_data}, 64'd0);
      rst_n = 1'b1;
      // R12: words and semaphore start at zero
      step("R12 initial", 5'd0, 1'b0, '0, 1'b1, SEMA, 1'b0, '0, 1'b0);
      // R1: shared writes seen by the other port
      step("R1 write", 5'd3, 1'b1, 32'hDEAD_BEEF, 1'b0, 5'd15, 1'b1, 32'h0000_1234, 1'b0);
      step("R1 cross read", 5'd15, 1'b0, '0, 1'b1, 5'd3, 1'b0, '0, 1'b1);
      // R2: acquire; R3: second reader refused
      step("R2 acquire", SEMA, 1'b0, '0, 1'b1, 5'd0, 1'b0, '0, 1'b0);
      step("R3 busy", 5'd0, 1'b0, '0, 1'b0, SEMA, 1'b0, '0, 1'b1);
      // R5: writing zero does not release
      step("R5 zero write", 5'd0, 1'b0, '0, 1'b0, SEMA, 1'b1, 32'hFFFF_FFFE, 1'b0);
      step("R5 still held", SEMA, 1'b0, '0, 1'b1, 5'd0, 1'b0, '0, 1'b0);
      // R4: release then reacquire by B
      step("R4 release", SEMA, 1'b1, 32'd1, 1'b0, 5'd0, 1'b0, '0, 1'b0);
      step("R4 reacquire", 5'd0, 1'b0, '0, 1'b0, SEMA, 1'b0, '0, 1'b1);
      // R6: A writes while B owns
      step("R6 write while held", 5'd5, 1'b1, 32'h0000_00A5, 1'b0, 5'd0, 1'b0, '0, 1'b0);
      step("R6 readback", 5'd0, 1'b0, '0, 1'b0, 5'd5, 1'b0, '0, 1'b1);
      step("R4 release B", 5'd0, 1'b0, '0, 1'b0, SEMA, 1'b1, 32'd1, 1'b0);
      // R8: both read the free semaphore together
      step("R8 race", SEMA, 1'b0, '0, 1'b1, SEMA, 1'b0, '0, 1'b1);
      // R4: read beats a same-cycle release
      step("R4 rel", SEMA, 1'b1, 32'd1, 1'b0, 5'd0, 1'b0, '0, 1'b0);
      step("R4 read vs clear", SEMA, 1'b0, '0, 1'b1, SEMA, 1'b1, 32'd1, 1'b0);
      step("R4 read wins", 5'd0, 1'b0, '0, 1'b0, SEMA, 1'b0, '0, 1'b1);
      step("R4 rel2", SEMA, 1'b1, 32'd1, 1'b0, 5'd0, 1'b0, '0, 1'b0);
      // R9: read of a word written in the same cycle returns old data, then holds
      step("R9 rd during wr", 5'd7, 1'b1, 32'h7777_0007, 1'b1, 5'd0, 1'b0, '0, 1'b0);
      idle("R9 hold");
      step("R9 new value", 5'd7, 1'b0, '0, 1'b1, 5'd0, 1'b0, '0, 1'b0);
      // R10: collision on one word
      step("R10 collide", 5'd9, 1'b1, 32'hAAAA_0009, 1'b0, 5'd9, 1'b1, 32'hBBBB_0009, 1'b0);
      step("R10 readback", 5'd9, 1'b0, '0, 1'b1, 5'd9, 1'b0, '0, 1'b1);
      // R11: out-of-range read and write
      step("R11 oor", 5'd20, 1'b1, 32'h1111_1111, 1'b1, 5'd31, 1'b0, '0, 1'b1);
      // R7: back-to-back forwarding, local state untouched
      step("R7 hold sema", SEMA, 1'b0, '0, 1'b1, 5'd0, 1'b0, '0, 1'b0);
      mode_v = 1'b1;
      step("R7 fwd", 5'd2, 1'b1, 32'h0000_0077, 1'b0, SEMA, 1'b1, 32'd1, 1'b0);
      step("R7 local reads", 5'd2, 1'b0, '0, 1'b1, SEMA, 1'b0, '0, 1'b1);
      step("R11 no fwd", 5'd25, 1'b1, 32'h2222_2222, 1'b0, 5'd4, 1'b1, 32'h4444_0004, 1'b0);
      idle("R7 single pulse");
      mode_v = 1'b0;
      step("R7 word2 local", 5'd2, 1'b0, '0, 1'b1, 5'd4, 1'b0, '0, 1'b1);
      idle("end");
      repeat (3) @(posedge clk);
      #5;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule